// File: doc/BRIEF.md
# Sixteen-Line Interrupt Expander

This block gathers sixteen external interrupt sources into one level-sensitive, active-high request for a host interrupt controller. Each source is brought into the clock domain through a short synchroniser. A pending bit is then latched for every line that goes high, and the host sees one request for as long as any pending line is also enabled.

The host works on a small synchronous 16-bit register bus. It has a latched pending view, which it acknowledges by writing ones. It has a raw view of the synchronised source levels. The enable register is changed through two write ports: one sets bits and the other clears them, and bits written as zero stay as they are. The usual start-up sequence writes all ones to the enable-clear port and then all ones to the pending port, which leaves every line quiet. Two of the lines (10 and 11) normally carry the two channels of an external dual UART, and they behave exactly like the other lines.

Top module: `irq_expander`

## Requirements
- R1: While reset is held low and after it is released, the pending register, the enable register, `irq_o` and `rd_data_o` are all zero.
- R2: Byte offsets decoded: 0x16 pending (read, write-one-to-clear), 0x18 raw level (read only), 0x1A enable set (write), 0x1C enable clear (write). Both 0x1A and 0x1C read back the enable register. Read data is registered. `rd_data_o` carries the value selected at the clock edge where `rd_en_i` is high, and it is zero after any edge without a read.
- R3: A source that is high at clock edge k reaches the raw view after edge k+2, sets its pending bit at edge k+2, and can raise `irq_o` from that edge on.
- R4: A pending bit stays set after its source falls, until the host acknowledges it.
- R5: A write to 0x16 clears the pending bits where the data is 1, and leaves the bits where the data is 0 unchanged.
- R6: If a line's synchronised level is high in the same cycle that its pending bit is acknowledged, the bit stays set.
- R7: A write to 0x1A sets the enable bits where the data is 1. Bits written as zero keep their value.
- R8: A write to 0x1C clears the enable bits where the data is 1. Bits written as zero keep their value.
- R9: `irq_o` is high exactly when the bitwise AND of pending and enable is nonzero.
- R10: A single all-ones write to 0x1C disables every line, and a single all-ones write to 0x16 clears every pending bit whose source is low.
- R11: The raw view at 0x18 shows the synchronised levels whatever the enables are. Writes to 0x18 change nothing.
- R12: Reads of any other offset return zero, and writes to any other offset change no register.
- R13: Lines 10 and 11 latch, acknowledge and raise the request in the same way as every other line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 16 | Asynchronous interrupt sources, one bit per line |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| rd_en_i | input | 1 | Read strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| irq_o | output | 1 | Active-high level request to the host |

## Verification
A source change takes two edges to reach the raw view and to set its pending bit. `irq_o` follows in the same cycle as the pending bit, and it follows an enable or acknowledge write one edge after that write. Read data appears one edge after the read strobe. The bench model holds the source history in a two-deep queue, so that each prediction uses the level sampled two edges earlier. It compares `irq_o` and `rd_data_o` at every falling edge, after all registers have settled. The directed checks wait exactly one, two or three edges according to these delays before they sample a result.

// File: rtl/irq_exp_pkg.sv
// Package: offsets and shared types of the interrupt expander.
// Assumes byte offsets fit in 8 bits; the host decodes these offsets.
package irq_exp_pkg;

    localparam logic [7:0] OFS_PEND  = 8'h16;
    localparam logic [7:0] OFS_RAW   = 8'h18;
    localparam logic [7:0] OFS_ENSET = 8'h1A;
    localparam logic [7:0] OFS_ENCLR = 8'h1C;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_RAW  = 2'd2,
        SEL_EN   = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic ack;
        logic en_set;
        logic en_clr;
    } wr_strb_t;

endpackage

// File: rtl/irq_exp_sync.sv
// Module: per-line synchroniser chain for the asynchronous sources.
// Assumes SYNC_STAGES >= 0; zero stages passes the sources straight through.
module irq_exp_sync #(
    parameter int LINES       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] src_i,
    output logic [LINES-1:0] lvl_o
);

    generate
        if (SYNC_STAGES == 0) begin : g_bypass
            assign lvl_o = src_i;
        end else begin : g_chain
            logic [LINES-1:0] stage_q [SYNC_STAGES];

            // First stage samples the raw sources.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= src_i;
            end

            for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
                // Each later stage re-samples the stage before it.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end

            assign lvl_o = stage_q[SYNC_STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/irq_exp_decode.sv
// Module: address decode of the host register bus into write strobes and a read select.
// Assumes one access per cycle; unmatched offsets give no strobe and SEL_NONE.
module irq_exp_decode
    import irq_exp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output wr_strb_t          strb_o,
    output rd_sel_e           sel_o
);

    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFS_ENSET);
    localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFS_ENCLR);

    // Write strobes: one per writable offset; the raw view has none.
    always_comb begin
        strb_o.ack    = wr_en_i && (addr_i == A_PEND);
        strb_o.en_set = wr_en_i && (addr_i == A_ENSET);
        strb_o.en_clr = wr_en_i && (addr_i == A_ENCLR);
    end

    // Read select: both enable ports read back the enable register.
    always_comb begin
        sel_o = SEL_NONE;
        if (rd_en_i) begin
            if (addr_i == A_PEND)                           sel_o = SEL_PEND;
            else if (addr_i == A_RAW)                       sel_o = SEL_RAW;
            else if (addr_i == A_ENSET || addr_i == A_ENCLR) sel_o = SEL_EN;
        end
    end

endmodule

// File: rtl/irq_exp_core.sv
// Module: pending and enable registers, plus the aggregated request.
// Assumes at most one write strobe per cycle; set from a high level beats an acknowledge.
module irq_exp_core
    import irq_exp_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_strb_t         strb_i,
    input  logic [LINES-1:0] wdata_i,
    input  logic [LINES-1:0] lvl_i,
    output logic [LINES-1:0] pend_o,
    output logic [LINES-1:0] en_o,
    output logic             irq_o
);

    logic [LINES-1:0] pend_q, en_q;
    logic [LINES-1:0] ack_mask, set_mask, clr_mask;

    // Masks used this cycle, zero unless their strobe is active.
    assign ack_mask = strb_i.ack    ? wdata_i : '0;
    assign set_mask = strb_i.en_set ? wdata_i : '0;
    assign clr_mask = strb_i.en_clr ? wdata_i : '0;

    // Pending latch: acknowledge first, then any high level re-pends.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_mask) | lvl_i;
    end

    // Enable register: set and clear ports touch only their one bits.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_mask) & ~clr_mask;
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign irq_o  = |(pend_q & en_q);

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_i.ack && |(wdata_i & ~lvl_i)) |=> ((pend_o & $past(wdata_i & ~lvl_i)) == '0)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|lvl_i) |=> ((pend_o & $past(lvl_i)) == $past(lvl_i))); // R6
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_i.ack |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R4
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        strb_i.en_set |=> ((en_o & $past(wdata_i)) == $past(wdata_i))); // R7
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        strb_i.en_clr |=> ((en_o & $past(wdata_i)) == '0)); // R8
    AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb_i.en_set || strb_i.en_clr) |=> $stable(en_o)); // R12

endmodule

// File: rtl/irq_exp_rdmux.sv
// Module: registered read-data path for the host bus.
// Assumes the select is valid in the cycle of the read strobe; zero otherwise.
module irq_exp_rdmux
    import irq_exp_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rd_sel_e          sel_i,
    input  logic [LINES-1:0] pend_i,
    input  logic [LINES-1:0] raw_i,
    input  logic [LINES-1:0] en_i,
    output logic [LINES-1:0] rd_data_o
);

    logic [LINES-1:0] rd_q;

    // Capture the selected view; no read gives zero.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else begin
            unique case (sel_i)
                SEL_PEND: rd_q <= pend_i;
                SEL_RAW:  rd_q <= raw_i;
                SEL_EN:   rd_q <= en_i;
                default:  rd_q <= '0;
            endcase
        end
    end

    assign rd_data_o = rd_q;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_NONE) |=> (rd_data_o == '0)); // R12

endmodule

// File: rtl/irq_expander.sv
// Module: top of the sixteen-line interrupt expander.
// Assumes a synchronous host bus with one access per cycle and asynchronous sources.
module irq_expander
    import irq_exp_pkg::*;
#(
    parameter int LINES       = 16,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [LINES-1:0]  wr_data_i,
    output logic [LINES-1:0]  rd_data_o,
    output logic              irq_o
);

    logic [LINES-1:0] lvl, pend, en;
    wr_strb_t         strb;
    rd_sel_e          sel;

    irq_exp_sync #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .lvl_o (lvl)
    );

    irq_exp_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .strb_o  (strb),
        .sel_o   (sel)
    );

    irq_exp_core #(.LINES(LINES)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb_i  (strb),
        .wdata_i (wr_data_i),
        .lvl_i   (lvl),
        .pend_o  (pend),
        .en_o    (en),
        .irq_o   (irq_o)
    );

    irq_exp_rdmux #(.LINES(LINES)) i_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .pend_i    (pend),
        .raw_i     (lvl),
        .en_i      (en),
        .rd_data_o (rd_data_o)
    );

    AST_RAW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFS_RAW)) |=> $stable(en)); // R11

endmodule

// File: tb/test_irq_expander.sv
module test_irq_expander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_data;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2ns clk = ~clk;

    irq_expander i_irq_expander (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wr_data_i(wdata),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    // Behavioural reference model.
    logic [15:0] hist[$];
    logic [15:0] m_pend = '0, m_en = '0, m_rd = '0, lvl_now;

    initial begin
        hist.push_back(16'h0);
        hist.push_back(16'h0);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_en = '0; m_rd = '0;
            hist.delete();
            hist.push_back(16'h0);
            hist.push_back(16'h0);
        end else begin
            lvl_now = hist.pop_front();
            hist.push_back(src);
            m_rd = '0;
            if (rd_en) begin
                case (addr)
                    8'h16: m_rd = m_pend;
                    8'h18: m_rd = lvl_now;
                    8'h1A, 8'h1C: m_rd = m_en;
                    default: m_rd = '0;
                endcase
            end
            if (wr_en) begin
                case (addr)
                    8'h16: m_pend = m_pend & ~wdata;
                    8'h1A: m_en = m_en | wdata;
                    8'h1C: m_en = m_en & ~wdata;
                    default: ;
                endcase
            end
            m_pend = m_pend | lvl_now;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (!done) begin
            check("R9 irq vs model", {15'h0, irq}, {15'h0, |(m_pend & m_en)});
            check("R2 read data vs model", rd_data, m_rd);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rd_data, exp);
    endtask

    initial begin
        #(4ns * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        check("R1 irq in reset", {15'h0, irq}, 16'h0);
        check("R1 rdata in reset", rd_data, 16'h0);
        @(negedge clk) rst_n = 1'b1;
        rd_chk(8'h16, 16'h0, "R1 pending after reset");
        rd_chk(8'h1A, 16'h0, "R1 enable after reset");

        // Latch every line, then run the all-ones start-up writes.
        src = 16'hFFFF; idle(3); src = 16'h0; idle(3);
        rd_chk(8'h16, 16'hFFFF, "R4 pending held after sources fall");
        wr(8'h1A, 16'hFFFF);
        check("R9 irq with all enabled", {15'h0, irq}, 16'h1);
        wr(8'h1C, 16'hFFFF);
        wr(8'h16, 16'hFFFF);
        rd_chk(8'h1A, 16'h0, "R10 all lines disabled");
        rd_chk(8'h16, 16'h0, "R10 all pending cleared");
        check("R10 irq low after init", {15'h0, irq}, 16'h0);

        // Enable set port keeps bits written as zero.
        wr(8'h1A, 16'h0C00);
        wr(8'h1A, 16'h0001);
        rd_chk(8'h1A, 16'h0C01, "R7 set port keeps zero bits");

        // The UART lines behave like any other line.
        src[10] = 1'b1; idle(1); src[10] = 1'b0; idle(3);
        rd_chk(8'h16, 16'h0400, "R13 line 10 latched");
        check("R13 irq from line 10", {15'h0, irq}, 16'h1);
        src[11] = 1'b1; idle(1); src[11] = 1'b0; idle(3);
        rd_chk(8'h16, 16'h0C00, "R13 line 11 latched");

        // Acknowledge only bit 10.
        wr(8'h16, 16'h0400);
        rd_chk(8'h16, 16'h0800, "R5 ack clears only one bits");
        check("R9 irq still high from line 11", {15'h0, irq}, 16'h1);
        wr(8'h1C, 16'h0800);
        rd_chk(8'h1C, 16'h0401, "R8 clear port keeps zero bits");
        check("R9 irq low when pending line disabled", {15'h0, irq}, 16'h0);

        // An acknowledge while the source is still high is overridden.
        src[0] = 1'b1; idle(3);
        wr(8'h16, 16'h0001);
        rd_chk(8'h16, 16'h0801, "R6 set wins over ack");
        src[0] = 1'b0; idle(3);
        wr(8'h16, 16'h0801);
        rd_chk(8'h16, 16'h0000, "R5 ack after source fell");

        // Raw view ignores enables and writes.
        src = 16'h00F0; idle(3);
        rd_chk(8'h18, 16'h00F0, "R11 raw view shows levels");
        wr(8'h18, 16'hFFFF);
        rd_chk(8'h18, 16'h00F0, "R11 raw view write ignored");
        rd_chk(8'h16, 16'h00F0, "R11 write to raw view left pending");
        src = 16'h0; idle(3);
        rd_chk(8'h18, 16'h0000, "R11 raw view follows fall");
        wr(8'h16, 16'hFFFF);

        // Two-edge synchroniser latency up to the request.
        wr(8'h1A, 16'h0020);
        src[5] = 1'b1;
        @(negedge clk); check("R3 irq low after one edge", {15'h0, irq}, 16'h0);
        @(negedge clk); check("R3 irq low after two edges", {15'h0, irq}, 16'h0);
        @(negedge clk); check("R3 irq high after three edges", {15'h0, irq}, 16'h1);
        src[5] = 1'b0; idle(3);
        wr(8'h16, 16'h0020);
        check("R9 irq drops after ack", {15'h0, irq}, 16'h0);

        // Unmapped offsets.
        wr(8'h20, 16'hFFFF);
        rd_chk(8'h20, 16'h0000, "R12 unmapped read is zero");
        rd_chk(8'h1A, 16'h0421, "R12 enable unchanged by unmapped write");
        rd_chk(8'h16, 16'h0000, "R12 pending unchanged by unmapped write");
        rd_chk(8'h1C, 16'h0421, "R2 clear port reads enable");
        idle(2);
        check("R2 rdata zero without read", rd_data, 16'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule